// File: doc/BRIEF.md
# Watchdog Timer with Selectable Count Source

This block is a down-counting watchdog. Software arms it by writing to a start strobe; from then on the counter falls toward zero and must be re-armed by another start write before it runs out. When it runs out, the block either raises an interrupt request or raises a reset request, depending on a mode input. The counter then reloads and keeps counting.

The count step comes from one of three paths. Two are derived from the CPU clock enable through a free-running prescaler: a divide-by-2 path, and a divide-by-16 or divide-by-128 path picked by a control bit. The third takes a slow tick from a secondary oscillator. That tick is asynchronous, so it is synchronized and edge-detected. Once software selects the oscillator path, the selection is locked until reset. In that mode the watchdog keeps counting through wait and hold, and any request to enter stop mode is refused. Everything runs in the CPU clock domain on single-cycle enables.

A small control register reads back the upper five counter bits and holds the prescaler select. The counter width is a parameter, and at the default of 15 bits the reload value is 0x7FFF.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter holds its all-ones reload value and does not count until the first start write. `irq_o`, `rst_req_o` and `stop_req_o` are 0, and `ctl_rdata_o` reads 0x1F.
- R2: A pulse on `start_wr_i` reloads the counter to all ones (0x7FFF at the default width) on the next edge and arms it. It also clears the prescaler. The strobe carries no data, so no written value can affect the reload.
- R3: With the oscillator path off and `div2_sel_i` = 0, the counter steps once per 16 enabled CPU cycles when control bit 7 is 0, and once per 128 when it is 1.
- R4: With the oscillator path off and `div2_sel_i` = 1, the counter steps once per 2 enabled CPU cycles, whatever control bit 7 holds.
- R5: With the oscillator path on, each rising edge of `osc_tick_i` steps the counter once, seen after two synchronizer flops and an edge register. In this mode `cpu_clk_en_i` has no effect.
- R6: With the oscillator path off, neither the counter nor the prescaler moves while `wait_i` or `hold_i` is 1. With it on, both inputs are ignored.
- R7: A step taken at count zero is an underflow. It reloads all ones and counting goes on. If `act_rst_i` = 0 it gives a one-cycle pulse on `irq_o`. If `act_rst_i` = 1 it sets `rst_req_o`, which then stays at 1 until reset.
- R8: `stop_req_wr_i` loads `stop_req_wdata_i` into the stop-mode request bit, which drives `stop_req_o`. While the oscillator path is on, a write of 1 is ignored and `stop_req_o` stays 0.
- R9: `ctl_rdata_o` gives the upper five counter bits in bits 4..0 (read-only) and 0 in bits 6..5. Bit 7 is the prescaler select, written from `ctl_wdata_i[7]` when `ctl_wr_i` is 1.
- R10: A 1 on `osc_sel_i` switches on the oscillator path from the next edge. After that, only reset can switch it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_en_i | input | 1 | CPU clock enable that feeds the prescaler |
| osc_tick_i | input | 1 | Asynchronous tick from the secondary oscillator |
| wait_i | input | 1 | CPU is in wait mode |
| hold_i | input | 1 | Bus is in hold state |
| div2_sel_i | input | 1 | Selects the divide-by-2 path |
| osc_sel_i | input | 1 | Request to switch on the oscillator path (sticky) |
| act_rst_i | input | 1 | Action on underflow: 0 interrupt, 1 reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| start_wr_i | input | 1 | Start register write strobe |
| stop_req_wr_i | input | 1 | Stop-mode request bit write strobe |
| stop_req_wdata_i | input | 1 | Stop-mode request bit write value |
| stop_req_o | output | 1 | Stop-mode request |
| irq_o | output | 1 | Underflow interrupt pulse |
| rst_req_o | output | 1 | Underflow reset request, held until reset |

## Verification
The assertions take it that software writes 0 to control bits 6..5 and that `osc_tick_i` changes no more often than every other CPU clock. The interrupt-pulse and tick-spacing properties depend on this: they expect no two steps on adjacent cycles. The stimulus holds each oscillator level for three cycles and writes control values with the reserved bits clear. It applies wait, hold and the clock enable as plain levels, changed only away from the sampling edge. A behavioural model in the bench follows the same inputs, so every output is compared on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Shadow state held beside the counter.
    typedef struct packed {
        logic psel;   // prescaler select, 1 = divide by 128
        logic osc;    // oscillator path latched on
        logic stop;   // stop-mode request bit
    } wdog_ctl_t;

    localparam int unsigned RB_W = 5;  // counter bits visible in the read data

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_i};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[STAGES-1] & ~st_q.last;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R5

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned PRE_W    = 7,
    parameter int unsigned FAST_LOG = 1,
    parameter int unsigned LO_LOG   = 4,
    parameter int unsigned HI_LOG   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  logic fast_i,
    input  logic hi_i,
    output logic tick_o
);
    localparam logic [PRE_W-1:0] MASK_FAST = PRE_W'((1 << FAST_LOG) - 1);
    localparam logic [PRE_W-1:0] MASK_LO   = PRE_W'((1 << LO_LOG) - 1);
    localparam logic [PRE_W-1:0] MASK_HI   = PRE_W'((1 << HI_LOG) - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        if (fast_i)    mask = MASK_FAST;
        else if (hi_i) mask = MASK_HI;
        else           mask = MASK_LO;

        tick_o = adv_i && !clr_i && ((pre_q & mask) == mask);

        pre_d = pre_q;
        if (clr_i)      pre_d = '0;
        else if (adv_i) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3
    AST_FROZEN_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i && !clr_i |=> $stable(pre_q)); // R6

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             act_rst_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam logic [CNT_W-1:0] RELOAD = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
        logic             rreq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start_i) begin
            st_d.cnt = RELOAD;
            st_d.run = 1'b1;
        end else if (st_q.run && step_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = RELOAD;
                if (act_rst_i) st_d.rreq = 1'b1;
                else           st_d.irq  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: RELOAD, run: 1'b0, irq: 1'b0, rreq: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rreq;

    AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == RELOAD)); // R2
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_RREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o); // R7
    AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run && !start_i |=> (cnt_o == RELOAD)); // R1

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int unsigned CNT_W       = 15,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRE_W       = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_clk_en_i,
    input  logic       osc_tick_i,
    input  logic       wait_i,
    input  logic       hold_i,
    input  logic       div2_sel_i,
    input  logic       osc_sel_i,
    input  logic       act_rst_i,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wdata_i,
    output logic [7:0] ctl_rdata_o,
    input  logic       start_wr_i,
    input  logic       stop_req_wr_i,
    input  logic       stop_req_wdata_i,
    output logic       stop_req_o,
    output logic       irq_o,
    output logic       rst_req_o
);
    import wdog_pkg::*;

    localparam int unsigned HI_LOG = PRE_W;

    wdog_ctl_t        ctl_d, ctl_q;
    logic             halt;
    logic             pre_adv;
    logic             pre_tick;
    logic             osc_edge;
    logic             step;
    logic [CNT_W-1:0] cnt;
    logic [4:0]       unused_ro_bits;

    assign unused_ro_bits = ctl_wdata_i[4:0];

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr_i) ctl_d.psel = ctl_wdata_i[7];
        if (osc_sel_i) ctl_d.osc = 1'b1;
        if (stop_req_wr_i && !(ctl_q.osc && stop_req_wdata_i))
            ctl_d.stop = stop_req_wdata_i;

        halt    = (wait_i || hold_i) && !ctl_q.osc;
        pre_adv = cpu_clk_en_i && !halt && !ctl_q.osc;
        step    = ctl_q.osc ? osc_edge : pre_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (osc_tick_i),
        .edge_o  (osc_edge)
    );

    wdog_prescaler #(
        .PRE_W    (PRE_W),
        .FAST_LOG (1),
        .LO_LOG   (4),
        .HI_LOG   (HI_LOG)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_wr_i),
        .adv_i  (pre_adv),
        .fast_i (div2_sel_i),
        .hi_i   (ctl_q.psel),
        .tick_o (pre_tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_wr_i),
        .step_i    (step),
        .act_rst_i (act_rst_i),
        .cnt_o     (cnt),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    assign ctl_rdata_o = {ctl_q.psel, 2'b00, cnt[CNT_W-1 -: RB_W]};
    assign stop_req_o  = ctl_q.stop & ~ctl_q.osc;

    AST_RSV_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |-> (ctl_wdata_i[6:5] == 2'b00)); // R9
    AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.osc |=> ctl_q.osc); // R10
    AST_STOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.osc && stop_req_wr_i && stop_req_wdata_i |=> !stop_req_o); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.osc && (wait_i || hold_i) && !start_wr_i |=> $stable(cnt)); // R6
    AST_OSC_IGNORES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.osc && !osc_edge && !start_wr_i |=> $stable(cnt)); // R5

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    localparam int CW   = 9;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 0, rst_n = 0;
    logic cpu_en = 0, osc_in = 0, wt = 0, hd = 0, d2 = 0, osel = 0, arst = 0;
    logic cwr = 0, swr = 0, pwr = 0, pdat = 0;
    logic [7:0] cwd = 0;
    logic [7:0] rdata;
    logic stop_o, irq, rreq;

    always #2.5 clk = ~clk;

    wdog_timer #(.CNT_W(CW)) u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .cpu_clk_en_i(cpu_en), .osc_tick_i(osc_in),
        .wait_i(wt), .hold_i(hd), .div2_sel_i(d2), .osc_sel_i(osel),
        .act_rst_i(arst), .ctl_wr_i(cwr), .ctl_wdata_i(cwd), .ctl_rdata_o(rdata),
        .start_wr_i(swr), .stop_req_wr_i(pwr), .stop_req_wdata_i(pdat),
        .stop_req_o(stop_o), .irq_o(irq), .rst_req_o(rreq)
    );

    int n_chk = 0, n_bad = 0;
    string phase = "R1";

    // behavioural model state
    int m_cnt, m_pre;
    bit m_run, m_irq, m_rst, m_psel, m_osc, m_stop, m_s1, m_s2, m_s3;
    int irq_seen = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit halt, otick, ptick, step;
        if (!rst_n) begin
            m_cnt = MAXV; m_pre = 0; m_run = 0; m_irq = 0; m_rst = 0;
            m_psel = 0; m_osc = 0; m_stop = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            halt  = (wt || hd) && !m_osc;
            otick = m_s2 && !m_s3;
            ptick = 0;
            if (swr) m_pre = 0;
            else if (!m_osc && cpu_en && !halt) begin
                if (d2)          ptick = (m_pre % 2) == 1;
                else if (m_psel) ptick = m_pre == 127;
                else             ptick = (m_pre % 16) == 15;
                m_pre = (m_pre + 1) % 128;
            end
            step  = m_osc ? otick : ptick;
            m_irq = 0;
            if (swr) begin m_cnt = MAXV; m_run = 1; end
            else if (m_run && step) begin
                if (m_cnt == 0) begin
                    m_cnt = MAXV;
                    if (arst) m_rst = 1; else m_irq = 1;
                end else m_cnt = m_cnt - 1;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_in;
            if (pwr && !(m_osc && pdat)) m_stop = pdat;
            if (cwr) m_psel = cwd[7];
            if (osel) m_osc = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            exp_rd = {m_psel, 2'b00, 5'(m_cnt >> (CW - 5))};
            chk(rdata == 8'(exp_rd), {phase, " read data"}, rdata, exp_rd);
            chk(irq == m_irq, {phase, " R7 irq"}, irq, m_irq);
            chk(rreq == m_rst, {phase, " R7 reset request"}, rreq, m_rst);
            chk(stop_o == (m_stop && !m_osc), {phase, " R8 stop"}, stop_o, m_stop && !m_osc);
            if (irq) irq_seen++;
        end
    end

    bit osc_gen = 0;
    int osc_div = 0;

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cwr = 0; swr = 0; pwr = 0; osel = 0;
            if (osc_gen) begin
                osc_div++;
                if (osc_div == 3) begin osc_div = 0; osc_in = ~osc_in; end
            end
        end
    endtask

    task automatic pulse_start();
        swr = 1; cyc(1);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        cwr = 1; cwd = v; cyc(1);
    endtask

    task automatic wr_stop(bit v);
        pwr = 1; pdat = v; cyc(1);
    endtask

    initial begin
        fork
            begin
                #900000;
                n_chk++; n_bad++;
                $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        join_none

        rst_n = 0; cyc(3); rst_n = 1;
        #2;
        // R1: reset state
        chk(rdata == 8'h1F, "R1 reset read data", rdata, 8'h1F);
        chk(!irq && !rreq && !stop_o, "R1 reset outputs", {irq, rreq, stop_o}, 0);
        cpu_en = 1; cyc(200);
        chk(rdata == 8'h1F, "R1 idle before start", rdata, 8'h1F);

        // R9: prescaler select written, read-only bits written with ones
        phase = "R9"; wr_ctl(8'h9F); cyc(1);
        chk(rdata[7] == 1'b1 && rdata[6:5] == 2'b00, "R9 select readback", rdata, 8'h9F);

        // R3: divide by 128, then divide by 16
        phase = "R3"; pulse_start(); cyc(2000);
        chk(u_wdog_timer.ctl_rdata_o[7] == 1'b1, "R3 divide-128 selected", rdata[7], 1);
        wr_ctl(8'h00); cyc(3000);

        // R2: repeated starts mid-count
        phase = "R2"; pulse_start(); cyc(1);
        chk(rdata[4:0] == 5'h1F, "R2 reload after start", rdata[4:0], 5'h1F);
        cyc(100); pulse_start(); cyc(50);

        // R4 and R7: divide by 2 through an underflow, gated enable pattern
        phase = "R4"; d2 = 1; wr_ctl(8'h80); cyc(300);
        for (int k = 0; k < 400; k++) begin cpu_en = (k % 3) != 0; cyc(1); end
        cpu_en = 1;
        phase = "R7"; cyc(1200);
        chk(irq_seen > 0, "R7 interrupt pulse seen", irq_seen, 1);

        // R6: halt in wait and hold
        phase = "R6"; wt = 1; cyc(300); wt = 0; hd = 1; cyc(300); hd = 0; cyc(100);

        // R8: stop bit writable without oscillator path
        phase = "R8"; wr_stop(1); cyc(1);
        chk(stop_o == 1'b1, "R8 stop set", stop_o, 1);
        wr_stop(0); cyc(1);
        chk(stop_o == 1'b0, "R8 stop cleared", stop_o, 0);
        wr_stop(1);

        // R5, R10: oscillator path, keeps running through wait/hold, locked
        phase = "R5"; osc_gen = 1; osel = 1; cyc(1);
        cyc(2); cpu_en = 0; wt = 1; hd = 1; pulse_start(); cyc(600);
        cpu_en = 1; wt = 0; hd = 0; cyc(300);
        phase = "R10"; osel = 0; cyc(50); wr_stop(1); cyc(2);
        chk(stop_o == 1'b0, "R10 oscillator path still locked", stop_o, 0);
        phase = "R7"; arst = 1; cyc(3200);
        chk(rreq == 1'b1, "R7 reset request held", rreq, 1);
        cyc(50);

        // R10: reset releases the oscillator path
        phase = "R10"; osc_gen = 0; arst = 0; rst_n = 0; cyc(2); rst_n = 1; #2;
        chk(!rreq && rdata == 8'h1F, "R10 reset clears", {rreq, rdata}, 8'h1F);
        wr_stop(1); cyc(1);
        chk(stop_o == 1'b1, "R10 stop allowed after reset", stop_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule